// File: doc/BRIEF.md
# Polled Priority Bus Arbiter

This block is the central controller of a system bus that several masters share. The masters do not have their own request and grant wires. All of them drive one wired request line, and all of them watch one bus-busy line. To hand the bus out, the controller puts a 3-bit master address on a broadcast grant bus and waits for the master at that address to answer with an accept pulse. If that master stays silent, the controller moves on to the next address down the priority order. Address 0 has the highest priority and is normally the memory port.

Each address is polled for a window whose length is set by a configuration input. A value of zero gives a one-cycle window. When a master accepts, the arbiter enters a tenure. During the tenure the grant address is frozen and a grant-valid output is high. The tenure lasts until the owning master drops bus-busy. If all eight addresses are polled and none accepts, the arbiter goes back to idle. It starts polling again only if the request line is still high. While bus-busy is high, no new poll sequence starts.

Top module: `polled_bus_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, `poll_vld_o` and `grant_vld_o` are low and `grant_addr_o` is 0.
- R2: From idle, polling starts only in a cycle where `req_i` is high and `busy_i` is low. On the following cycle `poll_vld_o` is high and `grant_addr_o` is 0. While `busy_i` is high in idle, `poll_vld_o` stays low.
- R3: Addresses are polled in ascending numeric order (0 first, 7 last). Each address stays on `grant_addr_o` with `poll_vld_o` high for W cycles, where W is `wait_cfg_i`, or 1 when `wait_cfg_i` is 0.
- R4: If `accept_i` is high in a polling cycle, then on the next cycle `grant_vld_o` is high, `poll_vld_o` is low, and `grant_addr_o` keeps the accepted address.
- R5: During a tenure, `grant_addr_o` is held steady and `poll_vld_o` is low. A further `accept_i` pulse changes nothing. `accept_i` outside polling does not start a grant.
- R6: A tenure ends when `busy_i` is low. `grant_vld_o` is low on the next cycle.
- R7: When address 7 finishes its window with no accept, the arbiter spends one cycle idle. It starts again at address 0 only if `req_i` is still high in that cycle.
- R8: `poll_vld_o` and `grant_vld_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Shared request line, high while any master wants the bus |
| busy_i | input | 1 | Shared bus-busy line, high while a master owns the bus |
| accept_i | input | 1 | Accept pulse from the master at the polled address |
| wait_cfg_i | input | 8 | Poll window per address in cycles (0 means 1) |
| grant_addr_o | output | 3 | Broadcast address being polled or granted |
| poll_vld_o | output | 1 | High while an address is being polled |
| grant_vld_o | output | 1 | High for the whole tenure of the accepted master |

## Verification
The bench measures the exact latency from request to grant for several window lengths and target addresses. This includes a zero setting, which a design without the one-cycle floor would get wrong by stalling or skipping addresses. It checks that the poll sequence starts again after all eight addresses time out. A design that forgets the request check would keep polling forever, and one that never restarts would leave a live request unserved. Other cases cover a busy bus holding off polling, accept pulses arriving during a tenure or in idle, and release on the cycle after bus-busy falls. Faults the bench looks for include a grant that jumps to a new address, a stray grant, and a tenure that outlives bus-busy.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_POLL = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_poll_timer.sv
module arb_poll_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] last_cnt;

  // a zero limit behaves as a one-cycle window
  assign last_cnt = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign expire_o = en_i && (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/arb_addr_step.sv
module arb_addr_step #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load_i)     addr_d = '0;
    else if (inc_i) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;
endmodule

// File: rtl/polled_bus_arbiter.sv
module polled_bus_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              busy_i,
  input  logic              accept_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic [ADDR_W-1:0] grant_addr_o,
  output logic              poll_vld_o,
  output logic              grant_vld_o
);
  arb_state_e state_q, state_d;
  logic addr_load, addr_inc, addr_last;
  logic tmr_en, tmr_clr, tmr_exp;

  assign tmr_en  = (state_q == ARB_POLL);
  assign tmr_clr = !tmr_en || addr_inc;

  arb_poll_timer #(.W(WAIT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .en_i     (tmr_en),
    .limit_i  (wait_cfg_i),
    .expire_o (tmr_exp)
  );

  arb_addr_step #(.AW(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (addr_load),
    .inc_i  (addr_inc),
    .addr_o (grant_addr_o),
    .last_o (addr_last)
  );

  always_comb begin
    state_d   = state_q;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (req_i && !busy_i) begin
          state_d   = ARB_POLL;
          addr_load = 1'b1;
        end
      end
      ARB_POLL: begin
        if (accept_i) begin
          state_d = ARB_OWN;
        end else if (tmr_exp) begin
          if (addr_last) state_d  = ARB_IDLE;
          else           addr_inc = 1'b1;
        end
      end
      ARB_OWN: begin
        if (!busy_i) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign poll_vld_o  = (state_q == ARB_POLL);
  assign grant_vld_o = (state_q == ARB_OWN);
endmodule

// File: rtl/polled_bus_arbiter_chk.sv
module polled_bus_arbiter_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              accept_i,
  input logic [ADDR_W-1:0] grant_addr_o,
  input logic              poll_vld_o,
  input logic              grant_vld_o
);
  // R8
  excl_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_vld_o && grant_vld_o));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_vld_o && !grant_vld_o && busy_i) |=> !poll_vld_o);

  // R3
  poll_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld_o && $past(poll_vld_o) && (grant_addr_o != $past(grant_addr_o)))
      |-> (grant_addr_o == $past(grant_addr_o) + 1'b1));

  // R4
  accept_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_vld_o && accept_i) |=> (grant_vld_o && $stable(grant_addr_o)));

  // R5
  tenure_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && busy_i) |=> (grant_vld_o && $stable(grant_addr_o)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !busy_i) |=> !grant_vld_o);
endmodule

bind polled_bus_arbiter polled_bus_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_i       (busy_i),
  .accept_i     (accept_i),
  .grant_addr_o (grant_addr_o),
  .poll_vld_o   (poll_vld_o),
  .grant_vld_o  (grant_vld_o)
);

// File: tb/tb_polled_bus_arbiter.sv
`timescale 1ns/1ps
module tb_polled_bus_arbiter;
  logic       clk;
  logic       rst_n;
  logic       req_i, busy_i, accept_i;
  logic [7:0] wait_cfg_i;
  logic [2:0] grant_addr_o;
  logic       poll_vld_o, grant_vld_o;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  polled_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_i(busy_i),
    .accept_i(accept_i), .wait_cfg_i(wait_cfg_i),
    .grant_addr_o(grant_addr_o), .poll_vld_o(poll_vld_o),
    .grant_vld_o(grant_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: {window cfg[18:11], target address[10:8], tenure cycles[7:0]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {8'd1, 3'd0, 8'd3},
    {8'd3, 3'd2, 8'd4},
    {8'd0, 3'd5, 8'd2},
    {8'd2, 3'd7, 8'd5},
    {8'd4, 3'd1, 8'd1},
    {8'd1, 3'd6, 8'd3}
  };

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] cfg, input logic [2:0] tgt, input logic [7:0] hold);
    int w;
    int k;
    int got;
    logic bad_ord;
    w = (cfg == 8'd0) ? 1 : int'(cfg);
    wait_cfg_i = cfg;
    got = 0;
    bad_ord = 1'b0;
    req_i = 1'b1;
    for (k = 1; k < 200; k++) begin
      @(negedge clk);
      accept_i = 1'b0;
      if (grant_vld_o) begin got = k; break; end
      if (poll_vld_o) begin
        // R3: address at this step follows the window count
        if (int'(grant_addr_o) != (k - 1) / w) bad_ord = 1'b1;
        if (grant_addr_o == tgt) begin
          accept_i = 1'b1; busy_i = 1'b1; req_i = 1'b0;
        end
      end
    end
    chk(!bad_ord, "R3 poll order", int'(bad_ord), 0);
    chk(got == 2 + int'(tgt) * w, "R4 grant latency", got, 2 + int'(tgt) * w);
    chk(grant_addr_o == tgt, "R4 grant address", int'(grant_addr_o), int'(tgt));
    for (int i = 0; i < int'(hold); i++) begin
      accept_i = (i == 0);  // R5: stray accept during tenure
      @(negedge clk);
      accept_i = 1'b0;
      chk(grant_vld_o && !poll_vld_o && grant_addr_o == tgt, "R5 tenure steady",
          int'(grant_addr_o), int'(tgt));
    end
    busy_i = 1'b0;
    @(negedge clk);
    chk(!grant_vld_o, "R6 release", int'(grant_vld_o), 0);
    @(negedge clk);
    chk(!poll_vld_o && !grant_vld_o, "R7 no restart without request",
        int'(poll_vld_o), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; busy_i = 1'b0; accept_i = 1'b0; wait_cfg_i = 8'd1;
    repeat (3) @(negedge clk);
    chk(!poll_vld_o && !grant_vld_o && grant_addr_o == 3'd0, "R1 reset", int'(poll_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!poll_vld_o && !grant_vld_o && grant_addr_o == 3'd0, "R1 after reset",
        int'(grant_vld_o), 0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][18:11], VEC[v][10:8], VEC[v][7:0]);

    // R5: accept while idle must not grant
    accept_i = 1'b1;
    @(negedge clk);
    accept_i = 1'b0;
    chk(!grant_vld_o && !poll_vld_o, "R5 idle accept ignored", int'(grant_vld_o), 0);

    // R2: busy bus holds off polling
    busy_i = 1'b1; req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!poll_vld_o, "R2 busy blocks poll", int'(poll_vld_o), 0);
    end
    busy_i = 1'b0;
    @(negedge clk);
    chk(poll_vld_o && grant_addr_o == 3'd0, "R2 poll starts at 0", int'(grant_addr_o), 0);
    accept_i = 1'b1; busy_i = 1'b1; req_i = 1'b0;
    @(negedge clk);
    accept_i = 1'b0;
    chk(grant_vld_o && grant_addr_o == 3'd0, "R4 grant at 0", int'(grant_vld_o), 1);
    busy_i = 1'b0;
    @(negedge clk);
    chk(!grant_vld_o, "R6 release", int'(grant_vld_o), 0);

    // R7: exhaustion with window 2, request held
    wait_cfg_i = 8'd2; req_i = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 16) chk(poll_vld_o && grant_addr_o == 3'd7, "R3 last address",
                       int'(grant_addr_o), 7);
      if (k == 17) chk(!poll_vld_o && !grant_vld_o, "R7 idle after exhaustion",
                       int'(poll_vld_o), 0);
      if (k == 18) chk(poll_vld_o && grant_addr_o == 3'd0, "R7 restart at 0",
                       int'(grant_addr_o), 0);
    end
    req_i = 1'b0;
    for (int k = 19; k <= 36; k++) begin
      @(negedge clk);
      if (k == 34 || k == 36) chk(!poll_vld_o && !grant_vld_o, "R7 stop when request gone",
                                  int'(poll_vld_o), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule